// File: doc/BRIEF.md
# GPIO Port with Programmable Pulldowns

This block is a bidirectional parallel port of configurable width that sits on a small synchronous register bus. Software sets a direction per pin, writes an output value into a data latch, and reads back a mix of the latch (for output pins) and the synchronised live pin level (for input pins). Each pin also has a weak pulldown. Software controls it through a write-only inhibit register in which a set bit turns the pulldown off.

The pulldown is asserted only when three conditions hold together: the build-time option is on, the pin's inhibit bit is clear, and the pin is an input. The pulldown enable is driven straight from the register state, with no extra pipeline stage. As a result it rises in the same cycle that the output enable falls, so a pin that is turned around from output to input is never left floating.

The bus is a single-cycle register port. Read data is combinational from the address while the read strobe is high, and is zero otherwise. Writes take effect at the clock edge that samples the write strobe.

Top module: `gpio_pd_port`

## Requirements
- R1: After reset every pin is an input (pin_oe = 0), the data latch is zero (pin_out = 0), and the inhibit register is zero. With the option on, pin_pd_en is therefore all ones.
- R2: A direction bit of 1 drives pin_oe high for that pin. A direction bit of 0 drives it low, which puts the pin in high impedance.
- R3: A write to offset 0x00 always loads the data latch, whatever the direction bits are. pin_out always shows the latch.
- R4: A read of offset 0x00 returns, bit by bit, the latch bit where the direction bit is 1 and the synchronised pin level where it is 0. A level that is present on pin_in before clock edge k is visible from edge k+1 onward.
- R5: The direction register at offset 0x04 is readable and writable, and a read returns the last value written.
- R6: The inhibit register sits at offset 0x10. With the option on, pin_pd_en[i] = ~inhibit[i] & ~dir[i], so a bit of 1 disables the pulldown and a bit of 0 enables it.
- R7: With the pulldown option off at build time, pin_pd_en is zero at all times, whatever is written to the inhibit register.
- R8: A read of offset 0x10 returns zero.
- R9: When a pin's direction changes from output to input and its inhibit bit is 0, pin_pd_en for that pin is high in the same cycle in which pin_oe goes low.
- R10: A read of any other offset returns zero. A write to any other offset changes no register.
- R11: bus_rdata is zero in every cycle in which bus_rd is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register offset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not reading |
| pin_in | input | 8 | Live pin level |
| pin_out | output | 8 | Output value per pin |
| pin_oe | output | 8 | Output enable per pin |
| pin_pd_en | output | 8 | Pulldown enable per pin |

## Verification
The hardest case to reach from the ports is the turnaround from output to input. The inhibit bit must already be clear, the pin must be an output, and the direction write must then drop that pin, so that pin_pd_en and pin_oe can be compared in the very cycle of the change. The stimulus first drives every pin as an output, then clears the inhibit bits, then clears the direction bits in several different masks. After that comes a long random phase in which writes to the direction and inhibit registers are mixed heavily with reads of all offsets. A second instance, built with the option off, receives the same stimulus, and the check on it is that its pulldowns never assert.

// File: rtl/gpio_pd_pkg.sv
package gpio_pd_pkg;
    localparam logic [15:0] OFS_DATA = 16'h0000;
    localparam logic [15:0] OFS_DIR  = 16'h0004;
    localparam logic [15:0] OFS_PDI  = 16'h0010;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DATA = 2'd1,
        SEL_DIR  = 2'd2,
        SEL_PDI  = 2'd3
    } reg_sel_e;

    function automatic reg_sel_e decode_ofs(input logic [15:0] ofs);
        reg_sel_e s;
        unique case (ofs)
            OFS_DATA: s = SEL_DATA;
            OFS_DIR:  s = SEL_DIR;
            OFS_PDI:  s = SEL_PDI;
            default:  s = SEL_NONE;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/gpio_pd_regs.sv
module gpio_pd_regs
    import gpio_pd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] data_q_o,
    output logic [W-1:0] dir_q_o,
    output logic [W-1:0] pdi_q_o
);
    typedef struct packed {
        logic [W-1:0] data;
        logic [W-1:0] dir;
        logic [W-1:0] pdi;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (sel)
                SEL_DATA: regs_d.data = wdata;
                SEL_DIR:  regs_d.dir  = wdata;
                SEL_PDI:  regs_d.pdi  = wdata;
                default:  regs_d      = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign data_q_o = regs_q.data;
    assign dir_q_o  = regs_q.dir;
    assign pdi_q_o  = regs_q.pdi;

    // R5: a direction write lands one edge later
    p_dir_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DIR) |=> (dir_q_o == $past(wdata)));

    // R3: a data write lands regardless of direction
    p_data_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_DATA) |=> (data_q_o == $past(wdata)));

    // R10: unmapped writes leave every register alone
    p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |=> ($stable(data_q_o) && $stable(dir_q_o) && $stable(pdi_q_o)));
endmodule

// File: rtl/gpio_pd_sync.sv
module gpio_pd_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [STAGES-1:0][W-1:0] sync_d, sync_q;

    always_comb begin
        sync_d[0] = din;
        for (int k = 1; k < STAGES; k++) sync_d[k] = sync_q[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign dout = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_pd_pinctl.sv
module gpio_pd_pinctl
    import gpio_pd_pkg::*;
#(
    parameter int W         = 8,
    parameter bit PD_OPTION = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rd_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] pdi_q,
    input  logic [W-1:0] pin_sync,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_pd_en,
    output logic [W-1:0] rdata
);
    logic [W-1:0] readback;

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign readback[i] = dir_q[i] ? data_q[i] : pin_sync[i];
        if (PD_OPTION) begin : g_pd
            assign pin_pd_en[i] = ~pdi_q[i] & ~dir_q[i];
        end else begin : g_nopd
            assign pin_pd_en[i] = 1'b0;
        end
    end

    assign pin_out = data_q;
    assign pin_oe  = dir_q;

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (sel)
                SEL_DATA: rdata = readback;
                SEL_DIR:  rdata = dir_q;
                default:  rdata = '0;
            endcase
        end
    end

    // R6: a pulldown is never on while the pin drives
    p_pd_vs_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_pd_en & pin_oe) == '0));

    if (!PD_OPTION) begin : g_chk_off
        // R7
        p_pd_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (pin_pd_en == '0));
    end
endmodule

// File: rtl/gpio_pd_port.sv
module gpio_pd_port
    import gpio_pd_pkg::*;
#(
    parameter int W           = 8,
    parameter int ADDR_W      = 5,
    parameter int SYNC_STAGES = 2,
    parameter bit PD_OPTION   = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_pd_en
);
    localparam int PAD_W = 16 - ADDR_W;

    reg_sel_e     sel;
    logic [W-1:0] data_q, dir_q, pdi_q, pin_sync;

    assign sel = decode_ofs({{PAD_W{1'b0}}, bus_addr});

    gpio_pd_regs #(.W(W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .sel(sel), .wdata(bus_wdata),
        .data_q_o(data_q), .dir_q_o(dir_q), .pdi_q_o(pdi_q)
    );

    gpio_pd_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(pin_in), .dout(pin_sync)
    );

    gpio_pd_pinctl #(.W(W), .PD_OPTION(PD_OPTION)) u_pins (
        .clk(clk), .rst_n(rst_n), .rd_en(bus_rd), .sel(sel),
        .data_q(data_q), .dir_q(dir_q), .pdi_q(pdi_q), .pin_sync(pin_sync),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pd_en(pin_pd_en), .rdata(bus_rdata)
    );

    // R8: the inhibit register reads as zero
    p_pdi_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_PDI) |-> (bus_rdata == '0));

    if (PD_OPTION) begin : g_handover
        // R9: pulldown takes over in the cycle the driver lets go
        p_pd_handover_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (((($past(pin_oe) & ~pin_oe & ~pdi_q) & ~pin_pd_en) == '0)));
    end
endmodule

// File: tb/sim_gpio_pd_port.sv
`timescale 1ns/1ps
module sim_gpio_pd_port;
    localparam int W = 8;
    localparam int AW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic bus_rd = 1'b0, bus_wr = 1'b0;
    logic [W-1:0] bus_wdata = '0, pin_in = '0;
    logic [W-1:0] rdata0, pout0, poe0, ppd0;
    logic [W-1:0] rdata1, pout1, poe1, ppd1;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    gpio_pd_port #(.W(W), .ADDR_W(AW), .PD_OPTION(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata0), .pin_in(pin_in),
        .pin_out(pout0), .pin_oe(poe0), .pin_pd_en(ppd0));

    gpio_pd_port #(.W(W), .ADDR_W(AW), .PD_OPTION(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1), .pin_in(pin_in),
        .pin_out(pout1), .pin_oe(poe1), .pin_pd_en(ppd1));

    // behavioural reference state
    logic [W-1:0] m_data, m_dir, m_pdi;
    logic [W-1:0] m_pipe [$];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_data <= '0; m_dir <= '0; m_pdi <= '0;
            m_pipe = '{'0, '0};
        end else begin
            m_pipe.push_back(pin_in);
            void'(m_pipe.pop_front());
            if (bus_wr) begin
                if (bus_addr == 5'h00) m_data <= bus_wdata;
                else if (bus_addr == 5'h04) m_dir <= bus_wdata;
                else if (bus_addr == 5'h10) m_pdi <= bus_wdata;
            end
        end
    end

    function automatic logic [W-1:0] exp_rdata();
        if (!bus_rd) return '0;                              // R11
        if (bus_addr == 5'h00) return (m_data & m_dir) | (m_pipe[0] & ~m_dir); // R4
        if (bus_addr == 5'h04) return m_dir;                // R5
        return '0;                                          // R8 / R10
    endfunction

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    // compare on every falling edge, before inputs move
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R3 pin_out", pout0, m_data);
            chk("R2 pin_oe", poe0, m_dir);
            chk("R6 R9 pin_pd_en", ppd0, ~m_pdi & ~m_dir);
            chk("R4 R5 R8 R10 R11 rdata", rdata0, exp_rdata());
            chk("R7 pin_pd_en option off", ppd1, '0);
            chk("R3 pin_out option off", pout1, m_data);
            chk("R4 rdata option off", rdata1, exp_rdata());
        end
    end

    task automatic step(input logic rd, input logic wr, input logic [AW-1:0] a,
                        input logic [W-1:0] wd, input logic [W-1:0] pins);
        @(negedge clk);
        #1;
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = wd; pin_in = pins;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values observed while held in reset
        chk("R1 pin_oe reset", poe0, '0);
        chk("R1 pin_out reset", pout0, '0);
        chk("R1 pin_pd_en reset", ppd0, '1);
        rst_n = 1'b1;
        // R3: data write while all pins are inputs
        step(0, 1, 5'h00, 8'hA5, 8'h3C);
        // R4: input readback after the synchroniser
        step(1, 0, 5'h00, 8'h00, 8'h3C);
        step(1, 0, 5'h00, 8'h00, 8'hC3);
        step(1, 0, 5'h00, 8'h00, 8'hC3);
        step(1, 0, 5'h00, 8'h00, 8'hC3);
        // R2/R5: mixed direction
        step(0, 1, 5'h04, 8'hF0, 8'h0F);
        step(1, 0, 5'h04, 8'h00, 8'h0F);
        step(1, 0, 5'h00, 8'h00, 8'h0F);
        step(1, 0, 5'h00, 8'h00, 8'h0F);
        // R6/R8: inhibit write and read
        step(0, 1, 5'h10, 8'h55, 8'h0F);
        step(1, 0, 5'h10, 8'h00, 8'h0F);
        // R10: unmapped write and read
        step(0, 1, 5'h08, 8'hFF, 8'h0F);
        step(1, 0, 5'h08, 8'h00, 8'h0F);
        step(1, 0, 5'h1F, 8'h00, 8'h0F);
        // R9: all outputs, clear inhibit, then release in masks
        step(0, 1, 5'h04, 8'hFF, 8'h00);
        step(0, 1, 5'h10, 8'h00, 8'h00);
        step(0, 1, 5'h04, 8'h0F, 8'h00);
        step(0, 1, 5'h04, 8'hFF, 8'h00);
        step(0, 1, 5'h04, 8'h00, 8'h00);
        // R7: inhibit writes on the option-off instance
        step(0, 1, 5'h10, 8'hAA, 8'h00);
        // R11: write with no read strobe
        step(0, 1, 5'h00, 8'h5A, 8'hFF);
        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] a;
            int pick = $urandom_range(0, 4);
            case (pick)
                0: a = 5'h00;
                1: a = 5'h04;
                2: a = 5'h10;
                default: a = AW'($urandom);
            endcase
            step(1'($urandom), 1'($urandom), a, W'($urandom), W'($urandom));
        end
        step(0, 0, 5'h00, 8'h00, 8'h00);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule